// File: doc/BRIEF.md
# Dual-Side Glitch-Free Clock Selector

This block picks the clock that drives one base clock domain from a set of candidate clocks. Rather than a single mux select, it keeps two selection sides, A and B. Each side has its own source-code register. Only one side drives the output at a time. Software reads the status register to learn which side is live. It loads a new source code into the idle side and then requests that side through the control register. The hardware then hands over between the two sides without producing a short pulse on the output.

The handover works as follows. The old side's gate is released through a two-flop synchroniser in the old clock's domain and closes on a falling edge of the old clock. Only after that does the new side's request pass through its own synchroniser. The new side's gate then opens on a falling edge of the new clock. The status register is clocked by the register clock and moves to the new side only once the new gate is seen open.

A source code `k` below `NUM_SRC` selects `clk_src[k]`. Larger codes select a constant-low clock. A side loaded with such a code never opens its gate, so a handover to it does not complete. Reset is synchronous and active-low, and it is sampled by every domain. The source clocks must therefore run while reset is held.

Top module: `clk_pingpong_sel`

## Requirements
- R1: While `rst_n` is low at a `cfg_clk` edge, the block returns to its reset state: `status` = 2'b01 (side A live), `ctrl_q` = 4'b0001, and both source codes are 0.
- R2: `clk_out` runs at the frequency of `clk_src[k]`, where k is the source code of the side that `status` shows as live.
- R3: A write to address 0 (side A code) or address 1 (side B code) is stored only if that side is neither live in `status` nor requested in `ctrl_q`. Otherwise it is ignored.
- R4: A write to address 2 (control) always stores `wr_data[3:2]` into `ctrl_q[3:2]`. These bits have no effect on clock selection. Low bits 2'b01 request side A and 2'b10 request side B.
- R5: A control write whose low bits are 2'b11 or 2'b00 leaves `ctrl_q[1:0]` and the live side unchanged.
- R6: A side request written while a handover is pending (`status` differs from `ctrl_q[1:0]`) is ignored.
- R7: Handover is glitch-free. No high or low phase of `clk_out` is shorter than the shortest half-period of the sources involved, and the two side gates are never open together.
- R8: `status` is always one-hot. It changes only to the side requested in `ctrl_q[1:0]`, and only after that side's gate has opened. Handovers complete in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Register and status clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_src | input | NUM_SRC | Candidate source clocks |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 side A code, 1 side B code, 2 control |
| wr_data | input | SRC_W | Write data |
| clk_out | output | 1 | Selected, glitch-free clock |
| status | output | 2 | Live side, bit 0 = A, bit 1 = B |
| src_a_q | output | SRC_W | Stored side A source code |
| src_b_q | output | SRC_W | Stored side B source code |
| ctrl_q | output | 4 | Stored control register |

## Verification
The hardest situation to reach is a second side request that lands while a handover is still in flight. At that moment both gates are shut and status still names the old side. The bench reaches it by writing a request on the cycle straight after the one that starts a handover, before either synchroniser has settled. The bench also measures every phase of the output in real time. It uses source periods with no common ratio, so gate edges fall at shifting offsets against both clocks.

// File: rtl/ckps_pkg.sv
// Package ckps_pkg
// Shared constants for the dual-side clock selector: register
// addresses and the one-hot side codes used by control and status.
package ckps_pkg;
    typedef enum logic [1:0] {
        ADDR_SRC_A = 2'd0,
        ADDR_SRC_B = 2'd1,
        ADDR_CTRL  = 2'd2,
        ADDR_NONE  = 2'd3
    } reg_addr_e;

    localparam int          NUM_SIDES = 2;
    localparam int          CTRL_W    = 4;
    localparam logic [1:0]  SIDE_A    = 2'b01;
    localparam logic [1:0]  SIDE_B    = 2'b10;
endpackage

// File: rtl/ckps_regs.sv
// Module ckps_regs
// Holds both side source codes and the control register.
// Assumes: status comes from the cfg_clk domain. A source write is
// refused while its side is live or requested. A side request is
// refused unless it is one-hot and no handover is pending.
module ckps_regs
    import ckps_pkg::*;
#(
    parameter int SRC_W = 4
) (
    input  logic              cfg_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [SRC_W-1:0]  wr_data,
    input  logic [1:0]        status,
    output logic [SRC_W-1:0]  src_a_q,
    output logic [SRC_W-1:0]  src_b_q,
    output logic [CTRL_W-1:0] ctrl_q
);
    logic a_locked;
    logic b_locked;
    logic pending;
    logic req_onehot;

    // Decide which writes may land this cycle.
    always_comb begin
        a_locked   = status[0] | ctrl_q[0];
        b_locked   = status[1] | ctrl_q[1];
        pending    = (status != ctrl_q[1:0]);
        req_onehot = (wr_data[1:0] == SIDE_A) || (wr_data[1:0] == SIDE_B);
    end

    // Side A source code register.
    always_ff @(posedge cfg_clk) begin
        if (!rst_n)
            src_a_q <= '0;
        else if (wr_en && wr_addr == ADDR_SRC_A && !a_locked)
            src_a_q <= wr_data;
    end

    // Side B source code register.
    always_ff @(posedge cfg_clk) begin
        if (!rst_n)
            src_b_q <= '0;
        else if (wr_en && wr_addr == ADDR_SRC_B && !b_locked)
            src_b_q <= wr_data;
    end

    // Control register: upper bits stored freely, side bits filtered.
    always_ff @(posedge cfg_clk) begin
        if (!rst_n) begin
            ctrl_q <= {2'b00, SIDE_A};
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            ctrl_q[3:2] <= wr_data[3:2];
            if (req_onehot && !pending)
                ctrl_q[1:0] <= wr_data[1:0];
        end
    end
endmodule

// File: rtl/ckps_side.sv
// Module ckps_side
// One selection side. It muxes the coded source clock, brings the
// enable request into that clock's domain through two flops, and
// opens or closes its output gate on a falling edge of that clock.
// Assumes: the code does not change while the gate is open, and
// peer_open is the other side's gate (an asynchronous level).
module ckps_side #(
    parameter int NUM_SRC = 9,
    parameter int SRC_W   = 4
) (
    input  logic [NUM_SRC-1:0] clk_src,
    input  logic [SRC_W-1:0]   code,
    input  logic               rst_n,
    input  logic               want,
    input  logic               peer_open,
    output logic               clk_gated,
    output logic               gate_open
);
    localparam logic [SRC_W:0] LIMIT = NUM_SRC[SRC_W:0];

    logic clk_sel;
    logic req;
    logic sync1;
    logic sync2;
    logic gate_q;

    // Pick the coded source; out-of-range codes give a dead clock.
    always_comb begin
        clk_sel = ({1'b0, code} < LIMIT) ? clk_src[code] : 1'b0;
        req     = want & ~peer_open;
    end

    // Two-flop synchroniser of the request into the selected domain.
    always_ff @(posedge clk_sel) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= req;
            sync2 <= sync1;
        end
    end

    // Gate changes only while the selected clock is low.
    always_ff @(negedge clk_sel) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else
            gate_q <= sync2;
    end

    assign clk_gated = clk_sel & gate_q;
    assign gate_open = gate_q;
endmodule

// File: rtl/ckps_status.sv
// Module ckps_status
// Brings both gate states into cfg_clk and keeps a one-hot status.
// Status moves only when exactly one gate is seen open, so it holds
// the old side for the whole of a handover.
module ckps_status
    import ckps_pkg::*;
(
    input  logic       cfg_clk,
    input  logic       rst_n,
    input  logic [1:0] gate_open,
    output logic [1:0] status
);
    logic [1:0] meta_q;
    logic [1:0] seen_q;

    // Two-flop synchroniser for the gate levels.
    always_ff @(posedge cfg_clk) begin
        if (!rst_n) begin
            meta_q <= 2'b00;
            seen_q <= 2'b00;
        end else begin
            meta_q <= gate_open;
            seen_q <= meta_q;
        end
    end

    // Status register updated once a single gate is seen open.
    always_ff @(posedge cfg_clk) begin
        if (!rst_n)
            status <= SIDE_A;
        else if (seen_q == SIDE_A || seen_q == SIDE_B)
            status <= seen_q;
    end
endmodule

// File: rtl/clk_pingpong_sel.sv
// Module clk_pingpong_sel
// Top of the dual-side clock selector: register file, two gated
// sides built by a generate loop with cross-coupled enables, a status
// synchroniser, and the OR of the two gated clocks.
// Assumes: source clocks run during reset; SRC_W >= 4 so that control
// writes fit in the data bus.
module clk_pingpong_sel
    import ckps_pkg::*;
#(
    parameter int NUM_SRC = 9,
    parameter int SRC_W   = 4
) (
    input  logic               cfg_clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] clk_src,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [SRC_W-1:0]   wr_data,
    output logic               clk_out,
    output logic [1:0]         status,
    output logic [SRC_W-1:0]   src_a_q,
    output logic [SRC_W-1:0]   src_b_q,
    output logic [CTRL_W-1:0]  ctrl_q
);
    logic [SRC_W-1:0]     side_code [NUM_SIDES];
    logic [NUM_SIDES-1:0] gate_open;
    logic [NUM_SIDES-1:0] side_clk;

    ckps_regs #(.SRC_W(SRC_W)) u_regs (
        .cfg_clk (cfg_clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .status  (status),
        .src_a_q (src_a_q),
        .src_b_q (src_b_q),
        .ctrl_q  (ctrl_q)
    );

    assign side_code[0] = src_a_q;
    assign side_code[1] = src_b_q;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        ckps_side #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_side (
            .clk_src   (clk_src),
            .code      (side_code[s]),
            .rst_n     (rst_n),
            .want      (ctrl_q[s]),
            .peer_open (gate_open[NUM_SIDES-1-s]),
            .clk_gated (side_clk[s]),
            .gate_open (gate_open[s])
        );
    end

    ckps_status u_status (
        .cfg_clk   (cfg_clk),
        .rst_n     (rst_n),
        .gate_open (gate_open),
        .status    (status)
    );

    // Only one gate is open at a time, so OR forms the output.
    assign clk_out = |side_clk;
endmodule

// File: rtl/clk_pingpong_sel_chk.sv
// Module clk_pingpong_sel_chk
// Checker bound to clk_pingpong_sel, sampling in the cfg_clk domain.
module clk_pingpong_sel_chk #(
    parameter int SRC_W = 4
) (
    input logic             cfg_clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [SRC_W-1:0] wr_data,
    input logic [1:0]       status,
    input logic [1:0]       gate_open,
    input logic [SRC_W-1:0] src_a_q,
    input logic [SRC_W-1:0] src_b_q,
    input logic [3:0]       ctrl_q
);
    p_reset_state_r1: assert property (@(posedge cfg_clk)
        !rst_n |=> (status == 2'b01 && ctrl_q == 4'b0001 &&
                    src_a_q == '0 && src_b_q == '0));

    p_locked_a_r3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && (status[0] || ctrl_q[0])) |=> $stable(src_a_q));

    p_locked_b_r3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && (status[1] || ctrl_q[1])) |=> $stable(src_b_q));

    p_upper_bits_r4: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2) |=> ctrl_q[3:2] == $past(wr_data[3:2]));

    p_bad_request_r5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && (wr_data[1:0] == 2'b11 || wr_data[1:0] == 2'b00))
        |=> $stable(ctrl_q[1:0]));

    p_busy_request_r6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && status != ctrl_q[1:0]) |=> $stable(ctrl_q[1:0]));

    p_gates_exclusive_r7: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        !(gate_open[0] && gate_open[1]));

    p_status_onehot_r8: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $countones(status) == 1);

    p_status_target_r8: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        !$stable(status) |-> status == ctrl_q[1:0]);
endmodule

bind clk_pingpong_sel clk_pingpong_sel_chk #(.SRC_W(SRC_W)) u_chk (
    .cfg_clk   (cfg_clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .status    (status),
    .gate_open (gate_open),
    .src_a_q   (src_a_q),
    .src_b_q   (src_b_q),
    .ctrl_q    (ctrl_q)
);

// File: tb/tb_clk_pingpong_sel.sv
`timescale 1ns/1ps
module tb_clk_pingpong_sel;
    localparam real CLK_PERIOD = 10.0;
    localparam int  NUM_SRC    = 9;
    localparam int  SRC_W      = 4;
    localparam real HALF0      = 3.7;
    localparam real HALF5      = 4.9;
    localparam real HALF8      = 5.9;
    localparam real MIN_HALF   = 3.7;
    localparam int  WINDOW     = 200;

    logic               cfg_clk = 1'b0;
    logic               rst_n   = 1'b0;
    logic [NUM_SRC-1:0] clk_src = '0;
    logic               wr_en   = 1'b0;
    logic [1:0]         wr_addr = '0;
    logic [SRC_W-1:0]   wr_data = '0;
    logic               clk_out;
    logic [1:0]         status;
    logic [SRC_W-1:0]   src_a_q, src_b_q;
    logic [3:0]         ctrl_q;

    clk_pingpong_sel #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) dut (
        .cfg_clk(cfg_clk), .rst_n(rst_n), .clk_src(clk_src),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clk_out(clk_out), .status(status), .src_a_q(src_a_q),
        .src_b_q(src_b_q), .ctrl_q(ctrl_q)
    );

    always #(CLK_PERIOD/2.0) cfg_clk = ~cfg_clk;
    always #(HALF0) clk_src[0] = ~clk_src[0];
    always #(HALF5) clk_src[5] = ~clk_src[5];
    always #(HALF8) clk_src[8] = ~clk_src[8];

    int n_chk = 0;
    int n_err = 0;

    // Behavioural reference state.
    logic [SRC_W-1:0] m_src_a = '0, m_src_b = '0;
    logic [3:0]       m_ctrl  = 4'b0001;
    logic [1:0]       st_prev = 2'b01;
    bit               cmp_on  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, well after the edge.
    always begin
        @(posedge cfg_clk);
        #(CLK_PERIOD/4.0);
        if (cmp_on) begin
            check(src_a_q === m_src_a, "R3", "src_a_q", int'(src_a_q), int'(m_src_a));
            check(src_b_q === m_src_b, "R3", "src_b_q", int'(src_b_q), int'(m_src_b));
            check(ctrl_q === m_ctrl, "R4", "ctrl_q", int'(ctrl_q), int'(m_ctrl));
            check($countones(status) == 1, "R8", "status onehot", int'(status), 1);
            if (status !== st_prev) begin
                check(status === m_ctrl[1:0], "R8", "status target",
                      int'(status), int'(m_ctrl[1:0]));
                st_prev = status;
            end
        end
    end

    // Output phase monitor for glitch detection.
    realtime last_t = 0.0;
    bit      mon_on = 0;
    int      short_cnt = 0;
    always @(clk_out) begin
        if (mon_on && last_t > 0.0 && ($realtime - last_t) < MIN_HALF - 0.01) begin
            short_cnt++;
            $display("FAIL R7 short phase: actual %0t expected >= %0.1f ns",
                     $realtime - last_t, MIN_HALF);
        end
        last_t = $realtime;
    end

    int  edge_cnt = 0;
    bit  counting = 0;
    always @(posedge clk_out) if (counting) edge_cnt++;

    // Register write with model update, driven on the falling edge.
    task automatic wr(input logic [1:0] addr, input logic [SRC_W-1:0] data);
        logic [1:0] st;
        @(negedge cfg_clk);
        st = status;
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        case (addr)
            2'd0: if (!(st[0] || m_ctrl[0])) m_src_a = data;
            2'd1: if (!(st[1] || m_ctrl[1])) m_src_b = data;
            2'd2: begin
                m_ctrl[3:2] = data[3:2];
                if ((data[1:0] == 2'b01 || data[1:0] == 2'b10) && st == m_ctrl[1:0])
                    m_ctrl[1:0] = data[1:0];
            end
            default: ;
        endcase
        @(negedge cfg_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_status(input logic [1:0] target, input string req);
        int n = 0;
        while (status !== target && n < 200) begin
            @(negedge cfg_clk);
            n++;
        end
        check(status === target, req, "handover completes", int'(status), int'(target));
    endtask

    task automatic freq_check(input real half, input string req);
        int exp;
        exp = $rtoi((WINDOW * CLK_PERIOD) / (2.0 * half));
        repeat (10) @(negedge cfg_clk);
        edge_cnt = 0; counting = 1;
        repeat (WINDOW) @(negedge cfg_clk);
        counting = 0;
        check(edge_cnt >= exp - 2 && edge_cnt <= exp + 2, req, "clk_out edges",
              edge_cnt, exp);
    endtask

    task automatic finish_run();
        check(short_cnt == 0, "R7", "short phases", short_cnt, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (8) @(negedge cfg_clk);
        rst_n = 1'b1;
        @(negedge cfg_clk);
        // R1 reset state
        check(status === 2'b01, "R1", "status", int'(status), 1);
        check(ctrl_q === 4'b0001, "R1", "ctrl_q", int'(ctrl_q), 1);
        check(src_a_q === '0 && src_b_q === '0, "R1", "sources",
              int'({src_a_q, src_b_q}), 0);
        cmp_on = 1;
        repeat (10) @(negedge cfg_clk);
        mon_on = 1;
        freq_check(HALF0, "R2");                 // R2 side A, code 0

        wr(2'd0, 4'd8);                          // R3 live side write ignored
        wr(2'd1, 4'd8);                          // R3 idle side write stored
        wr(2'd2, 4'b1110);                       // R4 request B, upper bits 11
        wr(2'd0, 4'd5);                          // R3 during handover: A still live
        wait_status(2'b10, "R8");
        freq_check(HALF8, "R2");                 // R2 side B, code 8

        wr(2'd2, 4'b0111);                       // R5 both bits: ignored
        wr(2'd2, 4'b1000);                       // R5 no bits: ignored
        repeat (30) @(negedge cfg_clk);
        check(status === 2'b10, "R5", "status kept", int'(status), 2);
        freq_check(HALF8, "R5");

        wr(2'd1, 4'd0);                          // R3 B live: ignored
        wr(2'd0, 4'd5);                          // R3 A idle: stored
        wr(2'd2, 4'b0001);                       // R8 switch back to A
        wr(2'd2, 4'b0110);                       // R6 request during handover
        wait_status(2'b01, "R6");
        repeat (20) @(negedge cfg_clk);
        check(status === 2'b01, "R6", "late request ignored", int'(status), 1);
        freq_check(HALF5, "R2");                 // R2 side A, code 5

        wr(2'd1, 4'd0);                          // R3 B idle: stored
        wr(2'd2, 4'b0010);                       // R7 switch to B (code 0)
        wait_status(2'b10, "R8");
        freq_check(HALF0, "R2");
        wr(2'd2, 4'b0001);                       // R7 switch to A (code 5)
        wait_status(2'b01, "R8");
        freq_check(HALF5, "R7");

        mon_on = 0;
        finish_run();
    end
endmodule